// File: doc/BRIEF.md
# Dimension-Order Cut-Through Torus Router

This block is the packet switch of one node in a three-dimensional torus. It has seven ports. Six connect to neighbours, one in each direction along X, Y and Z. The seventh connects to the local node. Every port is a pair of streams, one inbound and one outbound, so each neighbour link is a full-duplex point-to-point channel. The first word of every packet is a header. The header carries the destination coordinates and the packet length. The router compares the destination with the node's own coordinates, which come in on static inputs, and picks one output port.

Routing is dimension-ordered. The X offset is cleared first, then Y, then Z. A packet whose offsets are all zero leaves through the local port. Along each dimension the router takes the shorter way round the ring, and takes the plus direction when both ways are equally long. Switching is virtual cut-through. A packet is granted its output in the same cycle that its header arrives, provided the downstream buffer has room for the whole packet. Its words then stream through with one cycle of latency and are never stored whole. Each output keeps a credit count of free downstream words. When several inputs compete for one output, a round-robin arbiter picks the winner.

Top module: `torus_router`

## Requirements
- R1: While reset is high and in the cycle after it, every out_valid is 0 and every in_ready is 0. Each output starts with CRED credits.
- R2: The header word holds destination X in bits [15:12], Y in [11:8] and Z in [7:4]. While destination X differs from node X, the packet goes to port 0 (X plus) or port 1 (X minus).
- R3: When X matches but Y differs, the packet goes to port 2 (Y plus) or port 3 (Y minus). When X and Y match but Z differs, it goes to port 4 (Z plus) or port 5 (Z minus).
- R4: When all three coordinates match, the packet goes to port 6, the local port.
- R5: Within a dimension, let d = (dst - cur) mod SIZE. The plus port is used when d <= SIZE - d, which includes the tie. Otherwise the minus port is used.
- R6: Header bits [3:0] give the packet length in words, counting the header. A value of 0 means a one-word packet.
- R7: A word accepted on an input (in_valid and in_ready both high at a rising edge) appears on its output's out_valid/out_data right after that same edge. A header is accepted in the cycle its output is granted.
- R8: Once an output grants a packet, it carries only that input's words until the packet's last word. Packets never interleave on an output.
- R9: Among the inputs that are eligible for a free output, the first one found from a rotating pointer upward wins. After each grant the pointer moves to the winner's index plus 1, modulo 7.
- R10: An output grants a packet only if its credits are at least the packet length. Each word sent takes one credit. Each out_credit pulse returns one credit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| node_x | input | 4 | This node's X coordinate |
| node_y | input | 4 | This node's Y coordinate |
| node_z | input | 4 | This node's Z coordinate |
| in_valid | input | 7 | Inbound word valid, one bit per port |
| in_data | input | 112 | Inbound words, 16 bits per port, port p at [p*16 +: 16] |
| in_ready | output | 7 | Inbound word taken at this edge, one bit per port |
| out_valid | output | 7 | Outbound word valid, one bit per port (registered) |
| out_data | output | 112 | Outbound words, 16 bits per port (registered) |
| out_credit | input | 7 | One pulse per downstream word freed, one bit per port |

## Verification
in_ready is combinational. It is due in the same cycle as the header or word it accepts. The bench drives inputs one time unit after the rising edge and compares in_ready at the falling edge of that cycle. Forwarded words are due one edge after acceptance, so the reference model predicts the next cycle's out_valid and out_data at each falling edge and checks them at the following falling edge. The directed routing cases push a one-word packet at a falling edge. They then look for it on the outputs exactly two rising edges later: one edge for the driver to present it and one for the transfer. Credit returns are counted when they are driven, and the model applies them at the next edge.

// File: rtl/router_pkg.sv
package router_pkg;
  localparam int NP = 7;
  localparam int DW = 16;
  localparam int CW = 4;
  localparam int LW = 4;

  typedef enum logic [2:0] {
    PORT_XP, PORT_XM, PORT_YP, PORT_YM, PORT_ZP, PORT_ZM, PORT_LOCAL
  } port_e;

  function automatic logic [CW-1:0] hdr_dx(input logic [DW-1:0] h);
    return h[15:12];
  endfunction

  function automatic logic [CW-1:0] hdr_dy(input logic [DW-1:0] h);
    return h[11:8];
  endfunction

  function automatic logic [CW-1:0] hdr_dz(input logic [DW-1:0] h);
    return h[7:4];
  endfunction

  // effective length in words; a zero field stands for a lone header
  function automatic logic [LW-1:0] hdr_len(input logic [DW-1:0] h);
    return (h[3:0] == '0) ? LW'(1) : h[3:0];
  endfunction
endpackage

// File: rtl/dor_route.sv
module dor_route
  import router_pkg::*;
#(
  parameter int SIZE_X = 4,
  parameter int SIZE_Y = 4,
  parameter int SIZE_Z = 4
) (
  input  logic [CW-1:0] cur_x,
  input  logic [CW-1:0] cur_y,
  input  logic [CW-1:0] cur_z,
  input  logic [DW-1:0] hdr,
  output port_e         dir
);
  // 0: aligned, 1: plus way, 2: minus way
  function automatic logic [1:0] ring_step(input logic [CW-1:0] c, input logic [CW-1:0] d,
                                           input int n);
    int fwd;
    fwd = int'(d) - int'(c);
    if (fwd < 0) fwd = fwd + n;
    if (fwd == 0) return 2'd0;
    if (fwd <= n - fwd) return 2'd1;
    return 2'd2;
  endfunction

  logic [1:0] sx, sy, sz;

  always_comb begin
    sx = ring_step(cur_x, hdr_dx(hdr), SIZE_X);
    sy = ring_step(cur_y, hdr_dy(hdr), SIZE_Y);
    sz = ring_step(cur_z, hdr_dz(hdr), SIZE_Z);
    if (sx != 2'd0)      dir = (sx == 2'd1) ? PORT_XP : PORT_XM;
    else if (sy != 2'd0) dir = (sy == 2'd1) ? PORT_YP : PORT_YM;
    else if (sz != 2'd0) dir = (sz == 2'd1) ? PORT_ZP : PORT_ZM;
    else                 dir = PORT_LOCAL;
  end
endmodule

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
  parameter  int N  = 7,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gidx,
  output logic          any
);
  logic [IW-1:0] ptr_q;

  always_comb begin
    gnt  = '0;
    gidx = '0;
    any  = 1'b0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(ptr_q) + k) % N;
      if (!any && req[idx]) begin
        any      = 1'b1;
        gnt[idx] = 1'b1;
        gidx     = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else if (any) ptr_q <= (gidx == IW'(N - 1)) ? '0 : gidx + IW'(1);
  end
endmodule

// File: rtl/out_port.sv
module out_port
  import router_pkg::*;
#(
  parameter  int N    = 7,
  parameter  int CRED = 8,
  localparam int IW   = $clog2(N),
  localparam int CCW  = $clog2(CRED + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    req,
  input  logic [N*LW-1:0] len_flat,
  input  logic [N-1:0]    in_valid,
  input  logic [N*DW-1:0] in_data,
  input  logic            credit_ret,
  output logic [N-1:0]    sel,
  output logic            out_valid,
  output logic [DW-1:0]   out_data,
  output logic            locked,
  output logic [IW-1:0]   owner,
  output logic [CCW-1:0]  cred
);
  logic           lock_q;
  logic [IW-1:0]  own_q;
  logic [LW-1:0]  rem_q;
  logic [CCW-1:0] cred_q;
  logic [N-1:0]   elig, gnt;
  logic [IW-1:0]  gidx, src;
  logic           any, xfer;
  logic [LW-1:0]  glen;

  always_comb begin
    for (int i = 0; i < N; i++)
      elig[i] = req[i] && !lock_q && (int'(cred_q) >= int'(len_flat[i*LW +: LW]));
  end

  rr_arbiter #(.N(N)) u_arb (
    .clk  (clk),
    .rst  (rst),
    .req  (elig),
    .gnt  (gnt),
    .gidx (gidx),
    .any  (any)
  );

  always_comb begin
    src  = lock_q ? own_q : gidx;
    glen = len_flat[gidx*LW +: LW];
    xfer = lock_q ? in_valid[own_q] : any;
    sel  = lock_q ? (N'(1) << own_q) : gnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q    <= 1'b0;
      own_q     <= '0;
      rem_q     <= '0;
      cred_q    <= CCW'(CRED);
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= xfer;
      if (xfer) out_data <= in_data[src*DW +: DW];
      cred_q <= cred_q + CCW'(credit_ret) - CCW'(xfer);
      if (!lock_q) begin
        if (any && glen > LW'(1)) begin
          lock_q <= 1'b1;
          own_q  <= gidx;
          rem_q  <= glen - LW'(1);
        end
      end else if (in_valid[own_q]) begin
        rem_q <= rem_q - LW'(1);
        if (rem_q == LW'(1)) lock_q <= 1'b0;
      end
    end
  end

  assign locked = lock_q;
  assign owner  = own_q;
  assign cred   = cred_q;
endmodule

// File: rtl/torus_router.sv
module torus_router
  import router_pkg::*;
#(
  parameter  int SIZE_X = 4,
  parameter  int SIZE_Y = 4,
  parameter  int SIZE_Z = 4,
  parameter  int CRED   = 8,
  localparam int IW     = $clog2(NP),
  localparam int CCW    = $clog2(CRED + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CW-1:0]    node_x,
  input  logic [CW-1:0]    node_y,
  input  logic [CW-1:0]    node_z,
  input  logic [NP-1:0]    in_valid,
  input  logic [NP*DW-1:0] in_data,
  output logic [NP-1:0]    in_ready,
  output logic [NP-1:0]    out_valid,
  output logic [NP*DW-1:0] out_data,
  input  logic [NP-1:0]    out_credit
);
  port_e                   dir [NP];
  logic [NP-1:0]           busy;
  logic [NP-1:0]           lock_v;
  logic [NP*IW-1:0]        owner_flat;
  logic [NP*CCW-1:0]       cred_flat;
  logic [NP*LW-1:0]        len_flat;
  logic [NP-1:0][NP-1:0]   req;
  logic [NP-1:0][NP-1:0]   sel;

  for (genvar i = 0; i < NP; i++) begin : g_in
    dor_route #(.SIZE_X(SIZE_X), .SIZE_Y(SIZE_Y), .SIZE_Z(SIZE_Z)) u_route (
      .cur_x (node_x),
      .cur_y (node_y),
      .cur_z (node_z),
      .hdr   (in_data[i*DW +: DW]),
      .dir   (dir[i])
    );
    assign len_flat[i*LW +: LW] = hdr_len(in_data[i*DW +: DW]);
  end

  always_comb begin
    busy = '0;
    for (int o = 0; o < NP; o++)
      for (int i = 0; i < NP; i++)
        if (lock_v[o] && owner_flat[o*IW +: IW] == IW'(i)) busy[i] = 1'b1;
  end

  always_comb begin
    for (int o = 0; o < NP; o++)
      for (int i = 0; i < NP; i++)
        req[o][i] = !rst && in_valid[i] && !busy[i] && (int'(dir[i]) == o);
  end

  always_comb begin
    in_ready = '0;
    for (int o = 0; o < NP; o++) in_ready = in_ready | sel[o];
  end

  for (genvar o = 0; o < NP; o++) begin : g_out
    out_port #(.N(NP), .CRED(CRED)) u_out (
      .clk        (clk),
      .rst        (rst),
      .req        (req[o]),
      .len_flat   (len_flat),
      .in_valid   (in_valid),
      .in_data    (in_data),
      .credit_ret (out_credit[o]),
      .sel        (sel[o]),
      .out_valid  (out_valid[o]),
      .out_data   (out_data[o*DW +: DW]),
      .locked     (lock_v[o]),
      .owner      (owner_flat[o*IW +: IW]),
      .cred       (cred_flat[o*CCW +: CCW])
    );
  end
endmodule

// File: rtl/torus_router_chk.sv
module torus_router_chk #(
  parameter int NP   = 7,
  parameter int IW   = 3,
  parameter int CCW  = 4,
  parameter int CRED = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [NP-1:0]    in_valid,
  input logic [NP-1:0]    in_ready,
  input logic [NP-1:0]    out_valid,
  input logic [NP-1:0]    lock_v,
  input logic [NP*IW-1:0] owner_flat,
  input logic [NP*CCW-1:0] cred_flat
);
  assert_reset_quiet_R1: assert property (@(posedge clk) rst |=> (out_valid == '0))
    else $error("reset left an output valid");

  assert_one_cycle_forward_R7: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ($countones(out_valid) == $past($countones(in_valid & in_ready))))
    else $error("output words do not match accepted words");

  for (genvar g = 0; g < NP; g++) begin : g_chk
    assert_send_needs_credit_R10: assert property (@(posedge clk) disable iff (rst)
      out_valid[g] |-> ($past(cred_flat[g*CCW +: CCW]) != '0))
      else $error("word sent without credit");

    assert_credit_cap_R10: assert property (@(posedge clk) disable iff (rst)
      int'(cred_flat[g*CCW +: CCW]) <= CRED)
      else $error("credit above capacity");

    assert_owner_held_R8: assert property (@(posedge clk) disable iff (rst)
      (lock_v[g] && $past(lock_v[g])) |-> $stable(owner_flat[g*IW +: IW]))
      else $error("output owner changed inside a packet");
  end
endmodule

bind torus_router torus_router_chk #(.NP(NP), .IW(IW), .CCW(CCW), .CRED(CRED)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .lock_v     (lock_v),
  .owner_flat (owner_flat),
  .cred_flat  (cred_flat)
);

// File: tb/torus_router_bench.sv
module torus_router_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CRED = 8;
  localparam int SZ = 4;
  localparam int P = 7;

  typedef logic [15:0] wq_t[$];

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [P-1:0] iv = '0;
  logic [P-1:0] cr = '0;
  logic [15:0] idat[P];
  logic [P-1:0] in_ready, out_valid;
  logic [P*16-1:0] in_data, out_data;

  always_comb for (int i = 0; i < P; i++) in_data[i*16 +: 16] = idat[i];

  torus_router #(.SIZE_X(SZ), .SIZE_Y(SZ), .SIZE_Z(SZ), .CRED(CRED)) u_torus_router (
    .clk        (clk),
    .rst        (rst),
    .node_x     (4'd1),
    .node_y     (4'd1),
    .node_z     (4'd1),
    .in_valid   (iv),
    .in_data    (in_data),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_credit (cr)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act,
                     input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected output port from the routing requirements, node at (1,1,1)
  function automatic int exp_port(input logic [15:0] h);
    int d[3];
    d[0] = int'(h[15:12]);
    d[1] = int'(h[11:8]);
    d[2] = int'(h[7:4]);
    for (int k = 0; k < 3; k++) begin
      int up;
      up = ((d[k] - 1) % SZ + SZ) % SZ;
      if (up != 0) return (2 * up <= SZ) ? 2 * k : 2 * k + 1;
    end
    return 6;
  endfunction

  function automatic int plen(input logic [15:0] h);
    return (h[3:0] == 4'd0) ? 1 : int'(h[3:0]);
  endfunction

  // stimulus state: queues only grow; read pointers advance in the driver
  wq_t q[P];
  int rd[P];
  bit took[P];
  bit gaps = 1'b0;
  bit auto_cr = 1'b1;
  int sent_cnt[P];
  int ret_cnt[P];
  int man_req[P];
  int man_done[P];
  logic [15:0] log6[$];

  // reference model state
  int mlock[P], mown[P], mrem[P], mptr[P], mcred[P];
  bit exp_ov[P];
  logic [15:0] exp_od[P];
  bit mbusy[P], erdy[P], nov[P];
  logic [15:0] nod[P];
  int cyc = 0;

  function automatic int pending(input int i);
    return q[i].size() - rd[i];
  endfunction

  always @(posedge clk) begin
    #1;
    for (int i = 0; i < P; i++) begin
      if (took[i]) rd[i]++;
      if (pending(i) > 0 && (!gaps || $urandom_range(3) != 0)) begin
        iv[i]   = 1'b1;
        idat[i] = q[i][rd[i]];
      end else begin
        iv[i] = 1'b0;
      end
    end
    for (int o = 0; o < P; o++) begin
      cr[o] = 1'b0;
      if (man_req[o] > man_done[o]) begin
        cr[o] = 1'b1;
        man_done[o]++;
        ret_cnt[o]++;
      end else if (auto_cr && sent_cnt[o] > ret_cnt[o] && $urandom_range(1) == 1) begin
        cr[o] = 1'b1;
        ret_cnt[o]++;
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    for (int i = 0; i < P; i++) took[i] = iv[i] && in_ready[i];
    for (int o = 0; o < P; o++) begin
      if (out_valid[o]) sent_cnt[o]++;
    end
    if (out_valid[6]) log6.push_back(out_data[6*16 +: 16]);
    if (rst) begin
      for (int o = 0; o < P; o++) begin
        mlock[o] = 0; mown[o] = 0; mrem[o] = 0; mptr[o] = 0; mcred[o] = CRED;
        exp_ov[o] = 1'b0; exp_od[o] = '0;
      end
    end else begin
      for (int o = 0; o < P; o++) begin
        chk(out_valid[o] == exp_ov[o], "R7", $sformatf("out_valid[%0d]", o),
            int'(out_valid[o]), int'(exp_ov[o]));
        if (exp_ov[o])
          chk(out_data[o*16 +: 16] == exp_od[o], "R8", $sformatf("out_data[%0d]", o),
              int'(out_data[o*16 +: 16]), int'(exp_od[o]));
      end
      for (int i = 0; i < P; i++) begin
        mbusy[i] = 1'b0; erdy[i] = 1'b0;
      end
      for (int o = 0; o < P; o++) if (mlock[o] != 0) mbusy[mown[o]] = 1'b1;
      for (int o = 0; o < P; o++) begin
        nov[o] = 1'b0; nod[o] = '0;
        if (mlock[o] != 0) begin
          erdy[mown[o]] = 1'b1;
          if (iv[mown[o]]) begin
            nov[o] = 1'b1;
            nod[o] = idat[mown[o]];
            mrem[o]--;
            if (mrem[o] == 0) mlock[o] = 0;
          end
        end else begin
          for (int k = 0; k < P; k++) begin
            int i;
            i = (mptr[o] + k) % P;
            if (!nov[o] && iv[i] && !mbusy[i] && exp_port(idat[i]) == o &&
                mcred[o] >= plen(idat[i])) begin
              nov[o] = 1'b1;
              nod[o] = idat[i];
              erdy[i] = 1'b1;
              mptr[o] = (i + 1) % P;
              if (plen(idat[i]) > 1) begin
                mlock[o] = 1; mown[o] = i; mrem[o] = plen(idat[i]) - 1;
              end
            end
          end
        end
      end
      for (int i = 0; i < P; i++)
        chk(in_ready[i] == erdy[i], "R9/R10", $sformatf("in_ready[%0d]", i),
            int'(in_ready[i]), int'(erdy[i]));
      for (int o = 0; o < P; o++) begin
        mcred[o] = mcred[o] + int'(cr[o]) - int'(nov[o]);
        exp_ov[o] = nov[o];
        exp_od[o] = nod[o];
      end
    end
  end

  task automatic route_case(input logic [15:0] h, input int port, input string req);
    int found;
    @(negedge clk);
    q[6].push_back(h);
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    found = -1;
    for (int o = 0; o < P; o++)
      if (out_valid[o] && out_data[o*16 +: 16] == h) found = o;
    chk(found == port, req, $sformatf("route of %h", h), found, port);
    repeat (2) @(posedge clk);
  endtask

  task automatic push_pkt(input int i, input logic [15:0] h, input logic [15:0] first_pay);
    q[i].push_back(h);
    for (int w = 1; w < plen(h); w++) q[i].push_back(first_pay + 16'(w - 1));
  endtask

  initial begin
    int base;
    for (int i = 0; i < P; i++) begin
      idat[i] = '0; rd[i] = 0; took[i] = 0;
      sent_cnt[i] = 0; ret_cnt[i] = 0; man_req[i] = 0; man_done[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == '0, "R1", "out_valid in reset", int'(out_valid), 0);
    chk(in_ready == '0, "R1", "in_ready in reset", int'(in_ready), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == '0, "R1", "out_valid after reset", int'(out_valid), 0);

    // routing: node (1,1,1), ring size 4
    route_case(16'h2301, 0, "R2");
    route_case(16'h0111, 1, "R5");
    route_case(16'h3111, 0, "R5");
    route_case(16'h1231, 2, "R3");
    route_case(16'h1101, 5, "R3");
    route_case(16'h1021, 3, "R3");
    route_case(16'h1110, 6, "R4");

    // round robin on the local output; pointer sits at 0
    @(negedge clk);
    base = log6.size();
    push_pkt(0, 16'h1112, 16'hA000);
    push_pkt(1, 16'h1112, 16'hB000);
    repeat (10) @(negedge clk);
    chk(log6.size() - base == 4, "R8", "local words", log6.size() - base, 4);
    if (log6.size() - base == 4) begin
      chk(log6[base+1] == 16'hA000, "R9", "first winner", int'(log6[base+1]), 'hA000);
      chk(log6[base+3] == 16'hB000, "R8", "second packet whole", int'(log6[base+3]), 'hB000);
    end
    push_pkt(1, 16'h1112, 16'hB100);
    repeat (6) @(negedge clk);
    base = log6.size();
    push_pkt(0, 16'h1112, 16'hA100);
    push_pkt(2, 16'h1112, 16'hC100);
    repeat (10) @(negedge clk);
    chk(log6.size() - base == 4, "R9", "local words", log6.size() - base, 4);
    if (log6.size() - base == 4)
      chk(log6[base+1] == 16'hC100, "R9", "rotated winner", int'(log6[base+1]), 'hC100);

    // credits: fresh reset, no automatic returns
    while (sent_cnt[0] != ret_cnt[0] || sent_cnt[6] != ret_cnt[6]) @(negedge clk);
    auto_cr = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    push_pkt(6, 16'h2116, 16'h5000);
    repeat (10) @(negedge clk);
    push_pkt(6, 16'h2113, 16'h6000);
    repeat (10) @(negedge clk);
    chk(in_ready[6] == 1'b0, "R10", "ready while short of credit", int'(in_ready[6]), 0);
    chk(pending(6) == 3, "R10", "words held back", pending(6), 3);
    chk(out_valid[0] == 1'b0, "R10", "X plus idle", int'(out_valid[0]), 0);
    man_req[0]++;
    repeat (10) @(negedge clk);
    chk(pending(6) == 0, "R10", "packet sent after credit", pending(6), 0);
    auto_cr = 1'b1;

    // random traffic against the model (R6 zero-length headers included)
    gaps = 1'b1;
    for (int c = 0; c < 1500; c++) begin
      @(negedge clk);
      for (int i = 0; i < P; i++) begin
        if (pending(i) < 4 && $urandom_range(2) == 0) begin
          logic [15:0] h;
          h = {4'($urandom_range(3)), 4'($urandom_range(3)), 4'($urandom_range(3)),
               4'($urandom_range(5))};
          push_pkt(i, h, 16'($urandom));
        end
      end
    end
    gaps = 1'b0;
    for (int i = 0; i < P; i++) while (pending(i) > 0) @(negedge clk);
    repeat (30) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule